// File: doc/BRIEF.md
# Text Screen Buffer Block-Transfer Port

This block sits between an 8-bit host bus and a text-mode screen memory whose words are 16 bits wide. Each word holds one screen cell: a character code and the attribute (colour) byte that goes with it. The block lets the host move whole runs of cells through a single data register. It does not need an address for every cell. The host sets a start position, a cell count, a direction of travel and a transfer mode, then starts the block and streams bytes.

In character-only mode, each host byte is one cell. Writes merge the byte with a stored current-attribute value. Reads return only the character half of each word. In byte-pair mode, each cell takes two host bytes: the character first, then the attribute. On writes, the first byte is held back and the full word goes to memory when the second byte arrives. On reads, a word is fetched ahead of time and handed out in two halves before the position moves on.

A restart always reloads the position from the stored start register. This lets the host issue back-to-back blocks over the same area with only one control write each. The screen memory is external to the block and has a one-cycle synchronous read.

Top module: `txtbuf_xfer`

## Requirements
- R1: After reset, the status register (register 0) reads 0x00. No memory write or read strobe is active, and the attribute, start and count registers read 0.
- R2: The memory word layout is character in bits 7:0 and attribute in bits 15:8. A character-only write stores {current attribute, host byte} at the current position in the same cycle as the data-register write.
- R3: In byte-pair mode, the first data byte of a cell produces no memory write. The second byte writes {second byte, first byte}.
- R4: With the direction bit (control bit 2) clear, the position starts at the start register and rises by one per completed cell, wrapping from 0xFFFF to 0x0000.
- R5: With the direction bit set, the position falls by one per completed cell, wrapping from 0x0000 to 0xFFFF.
- R6: Busy (status bit 7) is set by a start (control bit 7) when the count register is non-zero. It clears once that many cells have completed. A start with a count of zero leaves the block idle.
- R7: Data-register writes are ignored when the block is idle or in read mode (control bit 0 set). No memory write results.
- R8: In read mode, a start fetches the word at the start position. Ready (status bit 6) rises once that word is held. In character-only mode, each data-register read returns the character of the current cell and advances to the next cell.
- R9: In byte-pair read mode, the first data read of a cell returns the character and the second returns the attribute. Only then does the position advance.
- R10: Every start reloads the position from the start register, so a repeated start without rewriting it covers the same cells again.
- R11: A change to the attribute register (register 1) during a block applies to character-only writes made after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Host register select: 0 control/status, 1 attribute, 2/3 start low/high, 4/5 count low/high, 6 data |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte (pops on the data register) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| mem_addr | output | ADDR_W | Screen memory word address |
| mem_we | output | 1 | Screen memory write enable |
| mem_wdata | output | 16 | Screen memory write word {attribute, character} |
| mem_re | output | 1 | Screen memory read enable |
| mem_rdata | input | 16 | Screen memory read word, valid the cycle after mem_re |

## Verification
The assertions assume that the host issues only one strobe per cycle. They also assume the host changes the mode bits only through a control write with the start bit, and that the memory returns read data exactly one cycle after its read enable. The bench drives every host access as a single-cycle strobe followed by an idle cycle. It writes the control register only to start a block. It polls ready before each data read in read mode, and its memory model has a fixed one-cycle read latency. Sweeps cover both modes, both directions and counts from one to four. Separate cases cover wrap-around at both ends of the address space, a zero count and restarts.

// File: rtl/txtbuf_pkg.sv
// Shared definitions for the text buffer block-transfer port.
// Assumes 8-bit host bytes and 16-bit screen words {attribute, character}.
package txtbuf_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Host register select codes
    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_ATTR   = 3'd1,
        RA_BASE_L = 3'd2,
        RA_BASE_H = 3'd3,
        RA_CNT_L  = 3'd4,
        RA_CNT_H  = 3'd5,
        RA_DATA   = 3'd6,
        RA_SPARE  = 3'd7
    } reg_sel_e;

    // Transfer configuration held between blocks
    typedef struct packed {
        logic down;     // address counts down
        logic pair;     // two host bytes per cell
        logic rd_mode;  // memory to host
    } xfer_mode_t;
endpackage

// File: rtl/txtbuf_regs.sv
// Host register file: mode, current attribute, start position and count.
// Generates a one-cycle start pulse on a control write with bit 7 set.
// Assumes ADDR_W and CNT_W lie between 9 and 16.
module txtbuf_regs
    import txtbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              ready,
    output xfer_mode_t        mode,
    output xfer_mode_t        start_mode,
    output logic              start,
    output logic [BYTE_W-1:0] attr,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] reg_rdata
);
    localparam int BH_W = ADDR_W - BYTE_W;
    localparam int CH_W = CNT_W - BYTE_W;

    reg_sel_e sel;
    assign sel        = reg_sel_e'(host_addr);
    assign start_mode = xfer_mode_t'(host_wdata[2:0]);
    assign start      = host_wr && (sel == RA_CTRL) && host_wdata[7];

    // Capture host register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            attr  <= '0;
            base  <= '0;
            count <= '0;
        end else if (host_wr) begin
            case (sel)
                RA_CTRL:   mode <= start_mode;
                RA_ATTR:   attr <= host_wdata;
                RA_BASE_L: base[BYTE_W-1:0] <= host_wdata;
                RA_BASE_H: base[ADDR_W-1:BYTE_W] <= host_wdata[BH_W-1:0];
                RA_CNT_L:  count[BYTE_W-1:0] <= host_wdata;
                RA_CNT_H:  count[CNT_W-1:BYTE_W] <= host_wdata[CH_W-1:0];
                default: ;
            endcase
        end
    end

    // Readback of configuration and status
    always_comb begin
        case (sel)
            RA_CTRL:   reg_rdata = {busy, ready, 3'b000, mode};
            RA_ATTR:   reg_rdata = attr;
            RA_BASE_L: reg_rdata = base[BYTE_W-1:0];
            RA_BASE_H: reg_rdata = BYTE_W'(base[ADDR_W-1:BYTE_W]);
            RA_CNT_L:  reg_rdata = count[BYTE_W-1:0];
            RA_CNT_H:  reg_rdata = BYTE_W'(count[CNT_W-1:BYTE_W]);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/txtbuf_seq.sv
// Block sequencer: position counter, remaining-cell counter, byte phase,
// and prefetch control for read mode.
// Assumes the memory returns data one cycle after a read enable.
module txtbuf_seq
    import txtbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_mode_t        start_mode,
    input  xfer_mode_t        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              data_wr,
    input  logic              data_rd,
    output logic              busy,
    output logic              ready,
    output logic              phase,
    output logic              fetch,
    output logic              capture,
    output logic              acc_wr,
    output logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  remain
);
    logic acc_rd;
    logic acc;

    assign acc_wr = data_wr && busy && !mode.rd_mode;
    assign acc_rd = data_rd && busy && mode.rd_mode && ready;
    assign acc    = acc_wr || acc_rd;
    assign step   = acc && (!mode.pair || phase);

    // Advance position, count and phase on accepted host data accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            ready   <= 1'b0;
            phase   <= 1'b0;
            fetch   <= 1'b0;
            capture <= 1'b0;
            addr    <= '0;
            remain  <= '0;
        end else if (start) begin
            addr    <= base;
            remain  <= count;
            phase   <= 1'b0;
            busy    <= (count != '0);
            fetch   <= start_mode.rd_mode && (count != '0);
            capture <= 1'b0;
            ready   <= 1'b0;
        end else begin
            fetch   <= 1'b0;
            capture <= fetch;
            if (capture) begin
                ready <= 1'b1;
            end
            if (acc) begin
                if (step) begin
                    addr   <= mode.down ? addr - 1'b1 : addr + 1'b1;
                    remain <= remain - 1'b1;
                    phase  <= 1'b0;
                    ready  <= 1'b0;
                    if (remain == CNT_W'(1)) begin
                        busy <= 1'b0;
                    end else if (mode.rd_mode) begin
                        fetch <= 1'b1;
                    end
                end else begin
                    phase <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/txtbuf_merge.sv
// Data path: merges host bytes with the attribute into memory words and
// splits prefetched words into host bytes.
// Assumes capture is high exactly in the cycle mem_rdata is valid.
module txtbuf_merge
    import txtbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              acc_wr,
    input  logic              step,
    input  logic              pair,
    input  logic              phase,
    input  logic [BYTE_W-1:0] attr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] char_q;
    logic [WORD_W-1:0] pre_q;

    // Hold the first byte of a pair and the prefetched word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
            pre_q  <= '0;
        end else begin
            if (acc_wr && pair && !phase) begin
                char_q <= host_wdata;
            end
            if (capture) begin
                pre_q <= mem_rdata;
            end
        end
    end

    // Build the outgoing word and select the outgoing byte
    always_comb begin
        mem_we    = acc_wr && step;
        mem_wdata = pair ? {host_wdata, char_q} : {attr, host_wdata};
        rd_byte   = (pair && phase) ? pre_q[WORD_W-1:BYTE_W] : pre_q[BYTE_W-1:0];
    end
endmodule

// File: rtl/txtbuf_xfer.sv
// Top of the text buffer block-transfer port. Decodes host data-register
// strobes and ties register file, sequencer and data path together.
// Assumes at most one of host_wr / host_rd per cycle.
module txtbuf_xfer
    import txtbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    output logic              mem_re,
    input  logic [15:0]       mem_rdata
);
    xfer_mode_t        cur_mode;
    xfer_mode_t        start_mode;
    logic              start;
    logic [BYTE_W-1:0] attr;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  count;
    logic [BYTE_W-1:0] reg_rdata;
    logic [BYTE_W-1:0] rd_byte;
    logic              busy, ready, phase, capture, acc_wr, step;
    logic [CNT_W-1:0]  remain;
    logic              data_wr, data_rd;
    logic              mode_rd, mode_pair, mode_down;

    assign data_wr   = host_wr && (host_addr == RA_DATA);
    assign data_rd   = host_rd && (host_addr == RA_DATA);
    assign mode_rd   = cur_mode.rd_mode;
    assign mode_pair = cur_mode.pair;
    assign mode_down = cur_mode.down;

    // Host readback: data port or register file
    always_comb begin
        host_rdata = (host_addr == RA_DATA) ? rd_byte : reg_rdata;
    end

    txtbuf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .busy(busy), .ready(ready), .mode(cur_mode),
        .start_mode(start_mode), .start(start), .attr(attr), .base(base),
        .count(count), .reg_rdata(reg_rdata)
    );

    txtbuf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .mode(cur_mode), .base(base), .count(count), .data_wr(data_wr),
        .data_rd(data_rd), .busy(busy), .ready(ready), .phase(phase),
        .fetch(mem_re), .capture(capture), .acc_wr(acc_wr), .step(step),
        .addr(mem_addr), .remain(remain)
    );

    txtbuf_merge u_merge (
        .clk(clk), .rst_n(rst_n), .capture(capture), .mem_rdata(mem_rdata),
        .acc_wr(acc_wr), .step(step), .pair(mode_pair), .phase(phase),
        .attr(attr), .host_wdata(host_wdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .rd_byte(rd_byte)
    );
endmodule

// File: rtl/txtbuf_xfer_chk.sv
// Assertion checker for txtbuf_xfer, attached with bind below.
// Assumes single-cycle host strobes and one-cycle memory read latency.
module txtbuf_xfer_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              phase,
    input logic [CNT_W-1:0]  remain,
    input logic              mode_rd,
    input logic              mode_pair,
    input logic              mode_down
);
    // R7
    write_only_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && !mode_rd));

    // R8
    fetch_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (busy && mode_rd));

    // R3
    pair_write_on_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_pair) |-> phase);

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mode_down) |=> (mem_addr == $past(mem_addr) + 1'b1));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_down) |=> (mem_addr == $past(mem_addr) - 1'b1));

    // R6
    done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (remain == '0));
endmodule

bind txtbuf_xfer txtbuf_xfer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .busy(busy), .phase(phase), .remain(remain),
    .mode_rd(mode_rd), .mode_pair(mode_pair), .mode_down(mode_down)
);

// File: tb/tb_txtbuf_xfer.sv
`timescale 1ns/1ps
module tb_txtbuf_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic        mem_re;
    logic [15:0] mem_rdata;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [15:0] ram [256];
    logic [15:0] log_addr [64];
    logic [15:0] log_data [64];
    int          log_n = 0;

    always #2 clk = ~clk;

    txtbuf_xfer dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Screen memory model, one-cycle read latency; logs every write
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
        if (rst_n && mem_we) begin
            if (log_n < 64) begin
                log_addr[log_n] <= mem_addr;
                log_data[log_n] <= mem_wdata;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic setup(input logic [15:0] b, input logic [15:0] n, input logic [7:0] at);
        hw(3'd1, at);
        hw(3'd2, b[7:0]);  hw(3'd3, b[15:8]);
        hw(3'd4, n[7:0]);  hw(3'd5, n[15:8]);
    endtask

    task automatic go(input bit rd, input bit pr, input bit dn);
        hw(3'd0, {1'b1, 4'b0000, dn, pr, rd});
    endtask

    function automatic logic [15:0] pos(input logic [15:0] b, input bit dn, input int i);
        return dn ? b - 16'(i) : b + 16'(i);
    endfunction

    initial begin
        logic [7:0] s, b;
        logic [15:0] a;
        int base0;
        for (int i = 0; i < 256; i++) ram[i] = {8'(i) ^ 8'h5A, 8'(i)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 mem_we", mem_we, 0);
        chk("R1 mem_re", mem_re, 0);
        hr(3'd0, s); chk("R1 status", s, 8'h00);
        hr(3'd1, s); chk("R1 attr", s, 8'h00);
        hr(3'd4, s); chk("R1 count", s, 8'h00);
        hr(3'd3, s); chk("R1 base", s, 8'h00);

        // R8 / R9 read sweep over mode, direction and count
        for (int pr = 0; pr < 2; pr++)
            for (int dn = 0; dn < 2; dn++)
                for (int n = 1; n <= 4; n++) begin
                    setup(16'h0040, 16'(n), 8'h00);
                    go(1'b1, pr[0], dn[0]);
                    hw(3'd6, 8'hEE);
                    chk("R7 write in read mode", log_n, 0);
                    for (int i = 0; i < n; i++) begin
                        for (int k = 0; k < 10; k++) begin
                            hr(3'd0, s);
                            if (s[6]) break;
                        end
                        chk("R8 ready", s[6], 1);
                        a = pos(16'h0040, dn[0], i);
                        hr(3'd6, b);
                        chk(pr ? "R9 char byte" : "R8 char byte", b, a[7:0]);
                        if (pr != 0) begin
                            hr(3'd6, b);
                            chk("R9 attr byte", b, a[7:0] ^ 8'h5A);
                        end
                    end
                    hr(3'd0, s); chk("R6 read block done", s[7], 0);
                end

        // R2 / R3 / R4 / R5 write sweep
        for (int pr = 0; pr < 2; pr++)
            for (int dn = 0; dn < 2; dn++)
                for (int n = 1; n <= 4; n++) begin
                    setup(16'h1230, 16'(n), 8'(8'h40 + n));
                    log_n = 0;
                    go(1'b0, pr[0], dn[0]);
                    hr(3'd0, s); chk("R6 busy after start", s[7], 1);
                    for (int i = 0; i < n; i++) begin
                        hw(3'd6, 8'(8'h20 + i + 8 * n));
                        if (pr != 0) begin
                            chk("R3 no write on first byte", log_n, i);
                            hw(3'd6, 8'(8'h80 + i));
                        end
                    end
                    chk("R6 cell count", log_n, n);
                    for (int i = 0; i < n; i++) begin
                        chk(dn ? "R5 address" : "R4 address", log_addr[i], pos(16'h1230, dn[0], i));
                        chk(pr ? "R3 word" : "R2 word", log_data[i],
                            {(pr != 0) ? 8'(8'h80 + i) : 8'(8'h40 + n), 8'(8'h20 + i + 8 * n)});
                    end
                    hr(3'd0, s); chk("R6 idle after count", s[7], 0);
                    hw(3'd6, 8'h77);
                    chk("R7 idle write ignored", log_n, n);
                end

        // R5 downward wrap
        setup(16'h0001, 16'd3, 8'h11); log_n = 0; go(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) hw(3'd6, 8'(i));
        chk("R5 wrap addr0", log_addr[0], 16'h0001);
        chk("R5 wrap addr2", log_addr[2], 16'hFFFF);

        // R4 upward wrap
        setup(16'hFFFE, 16'd3, 8'h11); log_n = 0; go(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) hw(3'd6, 8'(i));
        chk("R4 wrap addr1", log_addr[1], 16'hFFFF);
        chk("R4 wrap addr2", log_addr[2], 16'h0000);

        // R6 zero count
        setup(16'h0010, 16'd0, 8'h11); log_n = 0; go(1'b0, 1'b0, 1'b0);
        hr(3'd0, s); chk("R6 zero count idle", s[7], 0);
        hw(3'd6, 8'h55); chk("R6 zero count no write", log_n, 0);

        // R10 restart from the stored start position
        base0 = 16'h0300;
        setup(16'(base0), 16'd2, 8'h22); log_n = 0; go(1'b0, 1'b0, 1'b0);
        hw(3'd6, 8'hA0); hw(3'd6, 8'hA1);
        go(1'b0, 1'b0, 1'b0);
        hw(3'd6, 8'hB0); hw(3'd6, 8'hB1);
        chk("R10 restart count", log_n, 4);
        chk("R10 restart addr", log_addr[2], 16'h0300);
        chk("R10 restart next", log_addr[3], 16'h0301);

        // R11 attribute change mid-block
        setup(16'h0500, 16'd2, 8'h33); log_n = 0; go(1'b0, 1'b0, 1'b0);
        hw(3'd6, 8'hC0);
        hw(3'd1, 8'h44);
        hw(3'd6, 8'hC1);
        chk("R11 old attr", log_data[0], 16'h33C0);
        chk("R11 new attr", log_data[1], 16'h44C1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule